// File: doc/BRIEF.md
# Half-Float Colour Residual Generator

This block takes one 4x4 sub-block of half-precision RGBA pixels, one pixel per cycle in raster order, and turns it into the prediction residuals that a lossless colour buffer coder would entropy-code. Each colour half-float is read as a 15-bit unsigned integer by dropping its sign bit. Three planes are formed from those integers: red alone, green minus red, and blue minus green. Working on integers keeps every step exact, so no residual ever falls between two representable floats.

Inside each plane, the top-left value is sent as it is. The rest of the top row is predicted from the left neighbour and the rest of the left column from the pixel above. Interior pixels use left plus above minus upper-left. While the pixels come in, the block also checks whether the sub-block meets the conditions for compression. Alpha must be exactly 1.0 and no colour may be negative. If either fails, a flag tells the packer to store the sub-block uncompressed. An 8x8 tile is handled by feeding its four sub-blocks one after another.

Top module: `hfres_top`

## Requirements
- R1: Out of reset and whenever the block is collecting pixels, `in_ready` is high. A pixel is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The n-th pixel taken is the pixel at row n/4, column n%4. Cycles with `in_valid` low take nothing.
- R2: On the clock edge after the 16th pixel is taken, `in_ready` goes low and `out_valid` goes high. `out_valid` then stays high for exactly 48 consecutive cycles. `in_ready` returns high in the cycle after the last residual.
- R3: Residuals come out in plane order, with `out_plane` coded 0 for red, 1 for green minus red and 2 for blue minus green. Each plane gives 16 residuals in raster order.
- R4: Each channel value is bits 14:0 of the half-float. The plane values are R, G−R and B−G, taken as signed integer differences of those 15-bit values.
- R5: The residual of pixel (0,0) in each plane is the plane value itself.
- R6: For the other pixels of row 0, the residual is the value minus its left neighbour. For the other pixels of column 0, it is the value minus the pixel above.
- R7: For an interior pixel, the residual is the value minus (left + above − upper-left).
- R8: `out_res` holds the residual as a 17-bit two's complement number, reduced modulo 2^17.
- R9: `out_raw` is high on the last residual exactly when at least one pixel of this sub-block had alpha other than 0x3C00, or had bit 15 set in red, green or blue. The flag depends only on the current sub-block.
- R10: `out_last` is high only on the 48th residual. `out_raw` is low on every residual but the last.
- R11: While reset is high, and in the first cycle after it, `in_ready` is high and `out_valid` is low.
- R12: Pixels offered while `in_ready` is low are ignored and have no effect on the residuals of the next sub-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block is collecting pixels |
| in_red | input | 16 | Red half-float |
| in_green | input | 16 | Green half-float |
| in_blue | input | 16 | Blue half-float |
| in_alpha | input | 16 | Alpha half-float |
| out_valid | output | 1 | Residual valid |
| out_plane | output | 2 | Plane of the residual (0 R, 1 G−R, 2 B−G) |
| out_res | output | 17 | Residual, two's complement |
| out_last | output | 1 | Final residual of the sub-block |
| out_raw | output | 1 | Sub-block must be stored uncompressed (valid with out_last) |

## Verification
The first residual appears one cycle after the edge that takes the 16th pixel. The residuals follow on consecutive cycles, and `in_ready` returns one cycle after `out_last`. The bench therefore drives inputs and samples outputs on falling edges. It expects `out_valid` at the first falling edge after the last pixel and compares one residual at each of the next 48 falling edges. While the residuals stream out, it keeps `in_valid` high with random pixels. The next sub-block's residuals, which it computes from its own arrays, then show whether those stray pixels leaked in.

// File: rtl/hfres_pkg.sv
package hfres_pkg;

    localparam int HALF_W   = 16;
    localparam int CH_W     = HALF_W - 1;
    localparam int RES_W    = CH_W + 2;
    localparam int NPLANE   = 3;
    localparam logic [HALF_W-1:0] ALPHA_ONE = 16'h3C00;

    typedef enum logic [1:0] {
        PL_RED = 2'd0,
        PL_GMR = 2'd1,
        PL_BMG = 2'd2
    } plane_e;

    typedef enum logic {
        PH_FILL = 1'b0,
        PH_EMIT = 1'b1
    } phase_e;

    typedef struct packed {
        logic [HALF_W-1:0] r;
        logic [HALF_W-1:0] g;
        logic [HALF_W-1:0] b;
        logic [HALF_W-1:0] a;
    } pixel_t;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } colour_t;

    function automatic logic blocks_compress(pixel_t p);
        return (p.a != ALPHA_ONE) || p.r[HALF_W-1] || p.g[HALF_W-1] || p.b[HALF_W-1];
    endfunction

    function automatic colour_t strip_sign(pixel_t p);
        colour_t c;
        c.r = p.r[CH_W-1:0];
        c.g = p.g[CH_W-1:0];
        c.b = p.b[CH_W-1:0];
        return c;
    endfunction

    function automatic logic [RES_W-1:0] plane_value(colour_t c, plane_e p);
        logic [RES_W-1:0] r, g, b;
        r = {2'b00, c.r};
        g = {2'b00, c.g};
        b = {2'b00, c.b};
        case (p)
            PL_RED:  return r;
            PL_GMR:  return g - r;
            PL_BMG:  return b - g;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/hfres_capture.sv
module hfres_capture
    import hfres_pkg::*;
#(
    parameter int SIDE = 4,
    localparam int NPIX = SIDE * SIDE,
    localparam int IDX_W = $clog2(NPIX)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    acc_i,
    input  pixel_t  px_i,
    output colour_t store_o [NPIX],
    output logic    raw_o,
    output logic    done_o
);

    colour_t          store_q [NPIX];
    logic [IDX_W-1:0] wp_q;
    logic             raw_q;
    logic             first;
    logic             last;

    assign first = (wp_q == '0);
    assign last  = (wp_q == IDX_W'(NPIX - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            raw_q <= 1'b0;
            for (int i = 0; i < NPIX; i++) store_q[i] <= '0;
        end else if (acc_i) begin
            store_q[wp_q] <= strip_sign(px_i);
            wp_q          <= last ? '0 : wp_q + IDX_W'(1);
            raw_q         <= blocks_compress(px_i) | (raw_q & ~first);
        end
    end

    assign store_o = store_q;
    assign raw_o   = raw_q;
    assign done_o  = acc_i & last;

endmodule

// File: rtl/hfres_sequencer.sv
module hfres_sequencer
    import hfres_pkg::*;
#(
    parameter int SIDE = 4,
    localparam int NPIX = SIDE * SIDE,
    localparam int IDX_W = $clog2(NPIX),
    localparam int TOTAL = NPIX * NPLANE,
    localparam int CNT_W = $clog2(TOTAL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    output logic             emit_o,
    output plane_e           plane_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == CNT_W'(TOTAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FILL;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_FILL: begin
                    cnt_q <= '0;
                    if (done_i) phase_q <= PH_EMIT;
                end
                PH_EMIT: begin
                    cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
                    if (at_end) phase_q <= PH_FILL;
                end
                default: phase_q <= PH_FILL;
            endcase
        end
    end

    assign emit_o  = (phase_q == PH_EMIT);
    assign plane_o = plane_e'(cnt_q[CNT_W-1:IDX_W]);
    assign idx_o   = cnt_q[IDX_W-1:0];
    assign last_o  = emit_o & at_end;

endmodule

// File: rtl/hfres_predict.sv
module hfres_predict
    import hfres_pkg::*;
#(
    parameter int SIDE = 4,
    localparam int NPIX = SIDE * SIDE,
    localparam int IDX_W = $clog2(NPIX),
    localparam int COL_W = $clog2(SIDE)
) (
    input  colour_t          store_i [NPIX],
    input  plane_e           plane_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [RES_W-1:0] res_o
);

    logic [IDX_W-1:0] idx_l, idx_a, idx_d;
    logic [RES_W-1:0] v_cur, v_l, v_a, v_d, pred;
    logic             top_row, left_col;

    assign idx_l    = idx_i - IDX_W'(1);
    assign idx_a    = idx_i - IDX_W'(SIDE);
    assign idx_d    = idx_i - IDX_W'(SIDE + 1);
    assign top_row  = (idx_i[IDX_W-1:COL_W] == '0);
    assign left_col = (idx_i[COL_W-1:0] == '0);

    assign v_cur = plane_value(store_i[idx_i], plane_i);
    assign v_l   = plane_value(store_i[idx_l], plane_i);
    assign v_a   = plane_value(store_i[idx_a], plane_i);
    assign v_d   = plane_value(store_i[idx_d], plane_i);

    always_comb begin
        if (top_row && left_col)  pred = '0;
        else if (top_row)         pred = v_l;
        else if (left_col)        pred = v_a;
        else                      pred = v_l + v_a - v_d;
    end

    assign res_o = v_cur - pred;

endmodule

// File: rtl/hfres_top.sv
module hfres_top
    import hfres_pkg::*;
#(
    parameter int SIDE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_red,
    input  logic [15:0] in_green,
    input  logic [15:0] in_blue,
    input  logic [15:0] in_alpha,
    output logic        out_valid,
    output logic [1:0]  out_plane,
    output logic [16:0] out_res,
    output logic        out_last,
    output logic        out_raw
);

    localparam int NPIX  = SIDE * SIDE;
    localparam int IDX_W = $clog2(NPIX);

    pixel_t           px;
    colour_t          store [NPIX];
    logic             acc, raw, done, emit, last;
    plane_e           plane;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] res;

    assign px  = '{r: in_red, g: in_green, b: in_blue, a: in_alpha};
    assign acc = in_valid & in_ready;

    hfres_capture #(.SIDE(SIDE)) u_cap (
        .clk(clk), .rst(rst), .acc_i(acc), .px_i(px),
        .store_o(store), .raw_o(raw), .done_o(done)
    );

    hfres_sequencer #(.SIDE(SIDE)) u_seq (
        .clk(clk), .rst(rst), .done_i(done), .emit_o(emit),
        .plane_o(plane), .idx_o(idx), .last_o(last)
    );

    hfres_predict #(.SIDE(SIDE)) u_pred (
        .store_i(store), .plane_i(plane), .idx_i(idx), .res_o(res)
    );

    assign in_ready  = ~emit;
    assign out_valid = emit;
    assign out_plane = plane;
    assign out_res   = res;
    assign out_last  = last;
    assign out_raw   = last & raw;

endmodule

// File: rtl/hfres_checker.sv
module hfres_checker #(
    parameter int SIDE = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic [1:0] out_plane,
    input logic       out_last,
    input logic       out_raw
);

    localparam int NPIX  = SIDE * SIDE;
    localparam int TOTAL = NPIX * 3;

    int unsigned seen;

    always_ff @(posedge clk) begin
        if (rst)                       seen <= 0;
        else if (out_valid && out_last) seen <= 0;
        else if (out_valid)            seen <= seen + 1;
    end

    p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid));

    p_start_after_fill_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    p_burst_unbroken_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    p_ready_returns_r2: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (in_ready && !out_valid));

    p_plane_order_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (32'(out_plane) == seen / NPIX));

    p_last_position_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_last == (seen == TOTAL - 1)));

    p_raw_only_last_r10: assert property (@(posedge clk) disable iff (rst)
        out_raw |-> (out_last && out_valid));

endmodule

bind hfres_top hfres_checker #(.SIDE(SIDE)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_plane(out_plane), .out_last(out_last),
    .out_raw(out_raw)
);

// File: tb/hfres_top_tb_top.sv
`timescale 1ns/1ps
module hfres_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_red = '0, in_green = '0, in_blue = '0, in_alpha = '0;
    logic        out_valid;
    logic [1:0]  out_plane;
    logic [16:0] out_res;
    logic        out_last;
    logic        out_raw;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [15:0] br [16], bg [16], bb [16], ba [16];

    always #5 clk = ~clk;

    hfres_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_red(in_red), .in_green(in_green), .in_blue(in_blue), .in_alpha(in_alpha),
        .out_valid(out_valid), .out_plane(out_plane), .out_res(out_res),
        .out_last(out_last), .out_raw(out_raw)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // R4: plane values from the low 15 bits
    function automatic int pv(int p, int i);
        int r, g, b;
        r = int'(br[i] & 16'h7FFF);
        g = int'(bg[i] & 16'h7FFF);
        b = int'(bb[i] & 16'h7FFF);
        if (p == 0) return r;
        if (p == 1) return g - r;
        return b - g;
    endfunction

    // R5 R6 R7 R8: expected residual, modulo 2^17
    function automatic int exp_res(int p, int i);
        int row, col, pred;
        row = i / 4;
        col = i % 4;
        if (i == 0)        pred = 0;
        else if (row == 0) pred = pv(p, i - 1);
        else if (col == 0) pred = pv(p, i - 4);
        else               pred = pv(p, i - 1) + pv(p, i - 4) - pv(p, i - 5);
        return (pv(p, i) - pred) & 32'h1FFFF;
    endfunction

    function automatic bit exp_raw();
        for (int i = 0; i < 16; i++)
            if (ba[i] != 16'h3C00 || br[i][15] || bg[i][15] || bb[i][15]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic make_block(input int mode);
        for (int i = 0; i < 16; i++) begin
            ba[i] = 16'h3C00;
            case (mode)
                0: begin br[i] = 16'h3E00; bg[i] = 16'h3E00; bb[i] = 16'h3E00; end
                1: begin br[i] = 16'(16'h3000 + i * 37); bg[i] = 16'(16'h3100 + i * 5);
                         bb[i] = 16'(16'h2F00 + (i % 4) * 300); end
                2: begin br[i] = ((i % 2) == 0) ? 16'h7FFF : 16'h0000;
                         bg[i] = ((i % 3) == 0) ? 16'h0000 : 16'h7FFF;
                         bb[i] = ((i / 4) % 2 == 0) ? 16'h7FFF : 16'h0001; end
                default: begin br[i] = 16'($urandom) & 16'h7FFF; bg[i] = 16'($urandom) & 16'h7FFF;
                         bb[i] = 16'($urandom) & 16'h7FFF; end
            endcase
        end
        if (mode == 3) ba[15] = 16'h3C01;
        if (mode == 4) bb[0]  = bb[0] | 16'h8000;
        if (mode == 6) br[9]  = br[9] | 16'h8000;
        if (mode == 7) ba[5]  = 16'h0000;
    endtask

    task automatic run_block(input int mode);
        int k;
        make_block(mode);
        k = 0;
        while (k < 16) begin
            @(negedge clk);
            chk(in_ready === 1'b1 && out_valid === 1'b0, "R1 ready while filling",
                int'({in_ready, out_valid}), 2);
            if (($urandom % 4) == 0) begin
                in_valid = 1'b0;
                in_red   = 16'($urandom);
            end else begin
                in_valid = 1'b1;
                in_red = br[k]; in_green = bg[k]; in_blue = bb[k]; in_alpha = ba[k];
                k++;
            end
        end
        for (int n = 0; n < 48; n++) begin
            @(negedge clk);
            // R12: stray pixels offered while busy
            in_valid = 1'b1;
            in_red = 16'($urandom); in_green = 16'($urandom);
            in_blue = 16'($urandom); in_alpha = 16'($urandom);
            chk(out_valid === 1'b1 && in_ready === 1'b0, "R2 burst",
                int'({out_valid, in_ready}), 2);
            chk(out_plane === 2'(n / 16), "R3 plane order", int'(out_plane), n / 16);
            chk(out_res === 17'(exp_res(n / 16, n % 16)), "R5/R6/R7/R8/R12 residual",
                int'(out_res), exp_res(n / 16, n % 16));
            chk(out_last === (n == 47), "R10 last", int'(out_last), int'(n == 47));
            if (n == 47) chk(out_raw === exp_raw(), "R9 raw flag", int'(out_raw), int'(exp_raw()));
            else         chk(out_raw === 1'b0, "R10 raw low", int'(out_raw), 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R2 ready returns",
            int'({in_ready, out_valid}), 2);
    endtask

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R11 during reset",
            int'({in_ready, out_valid}), 2);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready === 1'b1 && out_valid === 1'b0, "R11 after reset",
            int'({in_ready, out_valid}), 2);
        run_block(0);
        run_block(1);
        run_block(2);
        run_block(3);
        run_block(5);   // R9: flag clears on the next clean sub-block
        run_block(4);
        run_block(6);
        run_block(7);
        run_block(5);
        for (int t = 0; t < 12; t++) run_block((t % 4 == 3) ? 6 : 5);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule